// File: doc/BRIEF.md
# Multiplying Dual-Slope Conversion Sequencer

This block is the digital control for one integrating converter channel in an impedance measurement array. Each conversion integrates the sensor current for a time set by a signed coefficient. It then holds the integrator and runs it back to zero with a reference current. While the reference runs, one shared counter steps up or down. The count is therefore the product of the input and the coefficient.

The counter is not cleared between conversions. Before each discharge it is preloaded with the running sum kept in the output latch, so the conversions of one stimulus period add into a single total. Feeding sine coefficients over a period gives the in-phase component, and cosine coefficients give the quadrature component. The integrator, the comparator and the reference sources stay outside the block. The block drives their switch controls and reads the comparator.

A conversion with a zero coefficient contributes nothing. A discharge that does not finish within a set number of cycles is cut short and reported as overrange. The running sum clamps at its signed limits rather than wrapping.

Top module: `msadc_sequencer`

## Requirements
- R1: After reset, `result_o` is 0, `result_valid_o`, `overrange_o`, `busy_o`, `sw_int_o`, `sw_refp_o` and `sw_refn_o` are 0, and `sw_rst_o` is 1.
- R2: A `start_i` pulse while `busy_o` is 0 begins a conversion. In that clock the counter is cleared and `coef_mag_i`, `coef_neg_i` and `period_end_i` are captured. A `start_i` pulse or any coefficient change while `busy_o` is 1 has no effect on the running conversion or its result.
- R3: `sw_int_o` is high for exactly `coef_mag_i` clocks, while the counter counts up from zero. A magnitude of 0 skips both integration and discharge, so the running sum is unchanged.
- R4: After integration, `HOLD_CYC` clocks follow with all four switch outputs low. In the first of these the counter is loaded with the output latch, which is zero for the first conversion of a period.
- R5: In the last hold clock `comp_i` is captured as the polarity, where 1 means the integrator is above zero. Discharge then drives `sw_refn_o` for polarity 1 or `sw_refp_o` for polarity 0. The four switch outputs are never high together.
- R6: In each discharge clock where `comp_i` still equals the polarity, the counter steps once. It steps up when the polarity is 1 and `coef_neg_i` is 0, or when the polarity is 0 and `coef_neg_i` is 1, and down otherwise. The first clock that differs ends discharge without a step.
- R7: The `T2_MAX`-th step forces discharge to end and sets `overrange_o`. The flag stays set until the first start of the next period.
- R8: The counter clamps at the signed `ACC_W`-bit maximum and minimum instead of wrapping.
- R9: One clock after discharge, the counter value is written to the output latch and `busy_o` falls. If the conversion was flagged as period end, `result_o` takes that value, `result_valid_o` is high for exactly one clock, and the latch is cleared.
- R10: `result_o` equals the clamped sum of the signed per-conversion step counts over all conversions of the period. `result_valid_o` stays low for every conversion not flagged as period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one conversion |
| coef_mag_i | input | COEF_W | Coefficient magnitude, integration length in clocks |
| coef_neg_i | input | 1 | Coefficient sign, 1 = negative |
| period_end_i | input | 1 | This conversion is the last of the stimulus period |
| comp_i | input | 1 | Comparator, 1 = integrator above zero |
| sw_int_o | output | 1 | Connect input current to integrator |
| sw_refp_o | output | 1 | Apply raising reference source |
| sw_refn_o | output | 1 | Apply lowering reference source |
| sw_rst_o | output | 1 | Short the integrating capacitor |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | ACC_W | Signed period total |
| result_valid_o | output | 1 | One-clock strobe on a new period total |
| overrange_o | output | 1 | A discharge in the period hit the step limit |

## Verification
A fault in the phase timer shows up on the switch outputs within the same conversion. The integrate or hold window has the wrong length, or the wrong reference source is driven. The bench counts these windows on every conversion. A fault in the running sum, a missed preload or a missed latch clear stays hidden until the period-end strobe. It then appears as a wrong `result_o`, so periods of one conversion are swept to expose each product at once. Multi-sample periods then check the accumulation.

// File: rtl/msadc_pkg.sv
package msadc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CHARGE,
      PH_HOLD,
      PH_DISCH,
      PH_WRITE
   } phase_t;
endpackage

// File: rtl/msadc_accum.sv
module msadc_accum #(
   parameter int ACC_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [ACC_W-1:0] load_val_i,
   input  logic             step_i,
   input  logic             up_i,
   output logic [ACC_W-1:0] q_o
);
   localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

   initial begin
      assert (ACC_W >= 4) else $error("accumulator too narrow");
   end

   logic [ACC_W-1:0] q_q;
   logic [ACC_W-1:0] stepped;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (up_i) stepped = (q_q == MAXV) ? q_q : q_q + 1'b1;
            else      stepped = (q_q == MINV) ? q_q : q_q - 1'b1;
         end

         AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (step_i && up_i && !clr_i && !load_i && q_q == MAXV) |=> (q_q == MAXV)); // R8
         AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (step_i && !up_i && !clr_i && !load_i && q_q == MINV) |=> (q_q == MINV)); // R8
      end else begin : g_wrap
         always_comb stepped = up_i ? q_q + 1'b1 : q_q - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_q <= '0;
      else if (clr_i)  q_q <= '0;
      else if (load_i) q_q <= load_val_i;
      else if (step_i) q_q <= stepped;
   end

   assign q_o = q_q;
endmodule

// File: rtl/msadc_phase_ctrl.sv
module msadc_phase_ctrl
   import msadc_pkg::*;
#(
   parameter int COEF_W   = 8,
   parameter int HOLD_CYC = 4,
   parameter int T2_MAX   = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COEF_W-1:0] coef_mag_i,
   input  logic              coef_neg_i,
   input  logic              period_end_i,
   input  logic              comp_i,
   input  logic [COEF_W-1:0] chg_cnt_i,
   output phase_t            phase_o,
   output logic              clr_o,
   output logic              load_o,
   output logic              step_o,
   output logic              up_o,
   output logic              tout_o,
   output logic              wr_o,
   output logic              last_o,
   output logic              pol_o
);
   localparam int TMR_TOP = (HOLD_CYC > T2_MAX) ? HOLD_CYC : T2_MAX;
   localparam int TMR_W   = $clog2(TMR_TOP + 1);
   localparam logic [TMR_W-1:0] HOLD_END = TMR_W'(HOLD_CYC - 1);
   localparam logic [TMR_W-1:0] DIS_END  = TMR_W'(T2_MAX - 1);

   initial begin
      assert (HOLD_CYC >= 2) else $error("hold must span at least two clocks");
      assert (T2_MAX >= 2) else $error("discharge limit too small");
   end

   phase_t            ph_q;
   logic [TMR_W-1:0]  tmr_q;
   logic [COEF_W-1:0] mag_q;
   logic              neg_q, last_q, pol_q;
   logic              same;

   assign same = (comp_i == pol_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         tmr_q  <= '0;
         mag_q  <= '0;
         neg_q  <= 1'b0;
         last_q <= 1'b0;
         pol_q  <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start_i) begin
               mag_q  <= coef_mag_i;
               neg_q  <= coef_neg_i;
               last_q <= period_end_i;
               tmr_q  <= '0;
               ph_q   <= (coef_mag_i == '0) ? PH_HOLD : PH_CHARGE;
            end
            PH_CHARGE: if (chg_cnt_i == COEF_W'(mag_q - 1'b1)) begin
               ph_q  <= PH_HOLD;
               tmr_q <= '0;
            end
            PH_HOLD: begin
               if (tmr_q == HOLD_END) begin
                  pol_q <= comp_i;
                  tmr_q <= '0;
                  ph_q  <= (mag_q == '0) ? PH_WRITE : PH_DISCH;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            PH_DISCH: begin
               if (!same || tmr_q == DIS_END) ph_q <= PH_WRITE;
               else                          tmr_q <= tmr_q + 1'b1;
            end
            PH_WRITE: ph_q <= PH_IDLE;
            default:  ph_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = ph_q;
   assign clr_o   = (ph_q == PH_IDLE) && start_i;
   assign load_o  = (ph_q == PH_HOLD) && (tmr_q == '0);
   assign step_o  = (ph_q == PH_CHARGE) || ((ph_q == PH_DISCH) && same);
   assign up_o    = (ph_q == PH_CHARGE) || (pol_q != neg_q);
   assign tout_o  = (ph_q == PH_DISCH) && same && (tmr_q == DIS_END);
   assign wr_o    = (ph_q == PH_WRITE);
   assign last_o  = last_q;
   assign pol_o   = pol_q;

   AST_DIS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DISCH) |-> (tmr_q <= DIS_END)); // R7
   AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE && ph_q != PH_WRITE) |=> ($stable(mag_q) && $stable(neg_q) && $stable(last_q))); // R2
   AST_HOLD_TO_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CHARGE) |=> (ph_q == PH_CHARGE || ph_q == PH_HOLD)); // R4
endmodule

// File: rtl/msadc_result.sv
module msadc_result #(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic             last_i,
   input  logic             tout_i,
   input  logic [ACC_W-1:0] acc_i,
   output logic [ACC_W-1:0] latch_o,
   output logic [ACC_W-1:0] result_o,
   output logic             valid_o,
   output logic             ovr_o
);
   logic [ACC_W-1:0] latch_q, res_q;
   logic             valid_q, ovr_q, fresh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         res_q   <= '0;
         valid_q <= 1'b0;
         ovr_q   <= 1'b0;
         fresh_q <= 1'b1;
      end else begin
         valid_q <= wr_i && last_i;
         if (wr_i) begin
            if (last_i) begin
               latch_q <= '0;
               res_q   <= acc_i;
               fresh_q <= 1'b1;
            end else begin
               latch_q <= acc_i;
            end
         end
         if (clr_i) begin
            fresh_q <= 1'b0;
            if (fresh_q) ovr_q <= 1'b0;
         end else if (tout_i) begin
            ovr_q <= 1'b1;
         end
      end
   end

   assign latch_o  = latch_q;
   assign result_o = res_q;
   assign valid_o  = valid_q;
   assign ovr_o    = ovr_q;

   AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R9
   AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (latch_q == '0)); // R9
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !clr_i) |=> ovr_q); // R7
endmodule

// File: rtl/msadc_sequencer.sv
module msadc_sequencer
   import msadc_pkg::*;
#(
   parameter int COEF_W   = 8,
   parameter int ACC_W    = 16,
   parameter int HOLD_CYC = 4,
   parameter int T2_MAX   = 4096,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COEF_W-1:0] coef_mag_i,
   input  logic              coef_neg_i,
   input  logic              period_end_i,
   input  logic              comp_i,
   output logic              sw_int_o,
   output logic              sw_refp_o,
   output logic              sw_refn_o,
   output logic              sw_rst_o,
   output logic              busy_o,
   output logic [ACC_W-1:0]  result_o,
   output logic              result_valid_o,
   output logic              overrange_o
);
   initial begin
      assert (COEF_W < ACC_W) else $error("coefficient must fit the counter");
   end

   phase_t           phase;
   logic             clr, load, step, up, tout, wr, last, pol;
   logic [ACC_W-1:0] acc, latch;

   msadc_phase_ctrl #(
      .COEF_W   (COEF_W),
      .HOLD_CYC (HOLD_CYC),
      .T2_MAX   (T2_MAX)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .coef_mag_i   (coef_mag_i),
      .coef_neg_i   (coef_neg_i),
      .period_end_i (period_end_i),
      .comp_i       (comp_i),
      .chg_cnt_i    (acc[COEF_W-1:0]),
      .phase_o      (phase),
      .clr_o        (clr),
      .load_o       (load),
      .step_o       (step),
      .up_o         (up),
      .tout_o       (tout),
      .wr_o         (wr),
      .last_o       (last),
      .pol_o        (pol)
   );

   msadc_accum #(
      .ACC_W    (ACC_W),
      .SATURATE (SATURATE)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .load_i     (load),
      .load_val_i (latch),
      .step_i     (step),
      .up_i       (up),
      .q_o        (acc)
   );

   msadc_result #(
      .ACC_W (ACC_W)
   ) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .wr_i     (wr),
      .last_i   (last),
      .tout_i   (tout),
      .acc_i    (acc),
      .latch_o  (latch),
      .result_o (result_o),
      .valid_o  (result_valid_o),
      .ovr_o    (overrange_o)
   );

   assign sw_int_o  = (phase == PH_CHARGE);
   assign sw_refn_o = (phase == PH_DISCH) && pol;
   assign sw_refp_o = (phase == PH_DISCH) && !pol;
   assign sw_rst_o  = (phase == PH_IDLE) || (phase == PH_WRITE);
   assign busy_o    = (phase != PH_IDLE);

   AST_SW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sw_int_o, sw_refp_o, sw_refn_o, sw_rst_o})); // R5
   AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (acc == $past(latch))); // R4
   AST_CHARGE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0)); // R2
endmodule

// File: tb/msadc_sequencer_bench.sv
module msadc_sequencer_bench;
   localparam int COEF_W   = 4;
   localparam int ACC_W    = 8;
   localparam int HOLD_CYC = 2;
   localparam int T2_MAX   = 40;
   localparam int SMAX     = 127;
   localparam int SMIN     = -128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [COEF_W-1:0] coef_mag_i = '0;
   logic              coef_neg_i = 1'b0;
   logic              period_end_i = 1'b0;
   logic              comp_i;
   logic              sw_int_o, sw_refp_o, sw_refn_o, sw_rst_o, busy_o;
   logic [ACC_W-1:0]  result_o;
   logic              result_valid_o, overrange_o;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;
   int vint = 0;
   int cur  = 0;
   int acc_m = 0;
   bit ovr_m = 1'b0;

   always #10 clk = ~clk;

   msadc_sequencer #(
      .COEF_W(COEF_W), .ACC_W(ACC_W), .HOLD_CYC(HOLD_CYC), .T2_MAX(T2_MAX), .SATURATE(1'b1)
   ) u_msadc_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .coef_mag_i(coef_mag_i),
      .coef_neg_i(coef_neg_i), .period_end_i(period_end_i), .comp_i(comp_i),
      .sw_int_o(sw_int_o), .sw_refp_o(sw_refp_o), .sw_refn_o(sw_refn_o),
      .sw_rst_o(sw_rst_o), .busy_o(busy_o), .result_o(result_o),
      .result_valid_o(result_valid_o), .overrange_o(overrange_o)
   );

   // integrator and comparator model
   always @(negedge clk) begin
      if (sw_rst_o)       vint <= 0;
      else if (sw_int_o)  vint <= vint + cur;
      else if (sw_refn_o) vint <= vint - 1;
      else if (sw_refp_o) vint <= vint + 1;
   end
   assign comp_i = (vint > 0);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         nerr = nerr + 1;
         $display("FAIL watchdog: run did not end act=%0d exp<=150000", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      nchk = nchk + 1;
      if (act != exp) begin
         nerr = nerr + 1;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int clamp(input int x);
      if (x > SMAX) return SMAX;
      if (x < SMIN) return SMIN;
      return x;
   endfunction

   task automatic convert(input int mag, input bit neg, input bit last, input int icur, input bit glitch);
      int v, n, ncyc, ci, ch, rp, rn, it;
      bit s, ov, up;
      v = mag * icur; n = 0; ov = 1'b0; s = (v > 0);
      if (mag != 0) begin
         while (1) begin
            v = s ? v - 1 : v + 1;
            if ((v > 0) != s) break;
            n = n + 1;
            if (n == T2_MAX) begin ov = 1'b1; break; end
         end
      end
      up = (s != neg);
      acc_m = clamp(acc_m + (up ? n : -n));
      ovr_m = ovr_m | ov;
      @(negedge clk);
      cur = icur; start_i = 1'b1; coef_mag_i = COEF_W'(mag);
      coef_neg_i = neg; period_end_i = last;
      @(negedge clk);
      start_i = 1'b0;
      ci = 0; ch = 0; rp = 0; rn = 0; it = 0;
      while (busy_o && it < 500) begin
         if (sw_int_o) ci++;
         if (!sw_int_o && !sw_refp_o && !sw_refn_o && !sw_rst_o) ch++;
         if (sw_refp_o) rp++;
         if (sw_refn_o) rn++;
         if (glitch && it == 1) begin
            start_i = 1'b1; coef_mag_i = COEF_W'(mag ^ 5); coef_neg_i = ~neg; period_end_i = ~last;
         end else begin
            start_i = 1'b0; coef_mag_i = COEF_W'(mag); coef_neg_i = neg; period_end_i = last;
         end
         it++;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk("R3 integrate clocks", ci, mag);
      chk("R4 hold clocks", ch, HOLD_CYC);
      if (mag != 0) begin
         chk("R6 discharge clocks", rp + rn, ov ? T2_MAX : n + 1);
         chk("R5 lowering source used", rn > 0, s);
         chk("R5 raising source used", rp > 0, !s);
      end else begin
         chk("R3 zero coef no discharge", rp + rn, 0);
      end
      chk("R9 valid strobe", result_valid_o, last);
      if (last) begin
         chk("R10 period total", $signed(result_o), acc_m);
         chk("R7 overrange flag", overrange_o, ovr_m);
         @(negedge clk);
         chk("R9 valid one clock", result_valid_o, 0);
         acc_m = 0; ovr_m = 1'b0;
      end
   endtask

   initial begin
      int tbl [8] = '{0, 5, 7, 5, 0, -5, -7, -5};
      int curs [3] = '{3, -2, 6};
      repeat (3) @(negedge clk);
      chk("R1 result", result_o, 0);
      chk("R1 valid", result_valid_o, 0);
      chk("R1 overrange", overrange_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 switches", {sw_int_o, sw_refp_o, sw_refn_o, sw_rst_o}, 4'b0001);
      rst_n = 1'b1;
      // single-conversion periods: every product in isolation (R6, R7)
      for (int c = 0; c < 3; c++)
         for (int m = 0; m < 16; m++)
            for (int sg = 0; sg < 2; sg++)
               convert(m, sg[0], 1'b1, curs[c], 1'b0);
      // start ignored while busy (R2)
      convert(9, 1'b0, 1'b1, 3, 1'b1);
      convert(9, 1'b1, 1'b1, -2, 1'b1);
      // stepwise sine period accumulation (R10, R4 preload)
      for (int k = 0; k < 8; k++)
         convert(tbl[k] < 0 ? -tbl[k] : tbl[k], tbl[k] < 0, k == 7, 2, 1'b0);
      // quadrature period with mixed input
      for (int k = 0; k < 8; k++)
         convert(tbl[(k + 2) % 8] < 0 ? -tbl[(k + 2) % 8] : tbl[(k + 2) % 8],
                 tbl[(k + 2) % 8] < 0, k == 7, -3, 1'b0);
      // saturation high and low (R8)
      for (int k = 0; k < 5; k++) convert(15, 1'b0, k == 4, 5, 1'b0);
      for (int k = 0; k < 5; k++) convert(15, 1'b1, k == 4, 5, 1'b0);
      // overrange cleared at next period start (R7)
      convert(15, 1'b0, 1'b0, 6, 1'b0);
      convert(2, 1'b0, 1'b1, 1, 1'b0);
      convert(2, 1'b0, 1'b1, 1, 1'b0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule